// File: doc/BRIEF.md
# Unlock-Sequence Flash Erase and Program Controller

This block drives a byte-wide parallel flash device whose commands are entered as short scripts of address/data writes. On a start pulse it either sector-erases one bank or programs a run of bytes into that bank. The bytes arrive from a valid/ready stream. Every command opens with two key writes to fixed bank offsets. After each command the controller polls the bank base. It reads the base twice in a row and XORs the two values, and the operation is finished once that XOR is zero. Every write strobe is followed by a programmable quiet gap before the bus is used again.

When an operation ends, the controller writes the read-mode code to the bank base. This also happens when polling gave up. It then pulses `done` and presents `error`. A poll that has not settled after `POLL_MAX` attempts ends programming at that byte. No further program command is issued after it. The bank is chosen by the most significant address bit, which is latched at start. `PROG_LEN` sets how many bytes one program pass writes, and `GAP_CYC` sets the length of the quiet gap.

Stream rules for the byte source: the source may raise `src_valid` at any time. While `src_valid` is high and `src_ready` is low, it must hold `src_data` steady. A byte is taken in the cycle where both are high. The controller raises `src_ready` only while it waits for the data of the next program command. It takes exactly one byte per program command, in offset order starting at 0. If the source holds `src_valid` low, the controller waits without limit and without touching the flash bus.

Top module: `fpc_flash_ctrl`

## Requirements
- R1: `busy` rises in the cycle after `start` is sampled high while idle. A `start` pulse that arrives while `busy` is high has no effect on the bus activity of the running operation.
- R2: Every erase or program command begins with a write of 0xAA at bank offset 0x555, followed by a write of 0x55 at bank offset 0x2AA.
- R3: An erase (`op_prog`=0) issues the key pair, then 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and finally 0x30@offset 0. After the erase, the bank reads as all 0xFF.
- R4: A program pass (`op_prog`=1) issues, for byte i from 0 to `PROG_LEN`-1, the key pair, then 0xA0@0x555, then the i-th streamed byte at offset i. Exactly one stream byte is accepted per program command.
- R5: Between any two write strobes, at least `GAP_CYC` cycles pass with no write strobe.
- R6: Polling reads the bank base in back-to-back pairs. The poll ends successfully on the first pair whose two values are equal, so a device that toggles for B reads costs 2*(ceil(B/2)+1) reads.
- R7: If `POLL_MAX` consecutive pairs differ, the poll times out. No further program command follows, and the operation ends with `error`=1.
- R8: Every operation ends with one write of 0xF0 at bank offset 0, after success or timeout. `done` is then high for exactly one cycle, in the first cycle that `busy` is low.
- R9: Every flash address carries the bank selected at start in its top bit (bit 13 with the default 13-bit bank offset).
- R10: `error` is cleared by the next accepted `start`, and `done` never lasts more than one cycle.
- R11: After reset the controller is idle with `busy`, `done`, `error`, `fl_we` and `fl_re` low. `fl_we` and `fl_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_prog | input | 1 | 0 = sector erase, 1 = program pass |
| bank_sel | input | 1 | Bank to operate on |
| src_valid | input | 1 | Stream byte available |
| src_ready | output | 1 | Controller takes a byte this cycle if valid |
| src_data | input | 8 | Stream byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Last operation timed out in polling |
| fl_addr | output | BANK_AW+1 | Flash address {bank, offset} |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, sampled at the edge ending an fl_re cycle |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe |

## Verification
`busy` is due one cycle after an accepted start. The first key write appears in that same cycle. Each write is followed by `GAP_CYC` quiet cycles, and each poll attempt takes two read cycles. `done` comes one cycle after the gap that follows the final read-mode write, and `error` is valid while `done` is high. The bench drives inputs at the falling edge and samples outputs there. After a start it checks `busy` at the next falling edge. It then waits on `done`, checks `done`, `busy` and `error` in that same half-cycle and checks that `done` has gone at the next one. A model that logs every write strobe and counts every read supplies the bus sequence and the poll cost, and both are compared with lists the bench computes from the requirements.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WRITE,
    S_GAP,
    S_RD_A,
    S_RD_B,
    S_FIN
  } fpc_state_t;

  typedef enum logic {
    OP_ERASE = 1'b0,
    OP_PROG  = 1'b1
  } fpc_op_t;

  // Command byte values written to the flash
  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] ERASE_ARM   = 8'h80;
  localparam logic [7:0] ERASE_GO    = 8'h30;
  localparam logic [7:0] PROG_ARM    = 8'hA0;
  localparam logic [7:0] BACK_TO_RD  = 8'hF0;

  // Fixed bank offsets used by the key writes
  localparam logic [11:0] KEY_OFS_HI = 12'h555;
  localparam logic [11:0] KEY_OFS_LO = 12'h2AA;

  localparam int unsigned STEP_W = 3;

endpackage

// File: rtl/fpc_gap_timer.sv
module fpc_gap_timer #(
  parameter int unsigned GAP_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int unsigned CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(GAP_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // Gap ends in the cycle where one count is left: GAP_CYC cycles in all
  assign expire = (cnt_q == CW'(1));

  AST_GAP_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !load |=> !expire);  // R5

endmodule

// File: rtl/fpc_toggle_poll.sv
module fpc_toggle_poll #(
  parameter int unsigned POLL_MAX = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       cap,
  input  logic       cmp,
  input  logic [7:0] rdata,
  output logic       same,
  output logic       limit
);
  localparam int unsigned NW = $clog2(POLL_MAX + 1);

  logic [7:0]    first_q;
  logic [NW-1:0] miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      first_q <= '0;
    else if (cap)
      first_q <= rdata;
  end

  // Two reads with no toggling bit between them XOR to zero
  assign same  = ((rdata ^ first_q) == 8'h00);
  assign limit = (miss_q == NW'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      miss_q <= '0;
    else if (clear)
      miss_q <= '0;
    else if (cmp && !same && !limit)
      miss_q <= miss_q + 1'b1;
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < NW'(POLL_MAX));  // R7

  AST_CAP_CMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap && cmp));  // R6

endmodule

// File: rtl/fpc_cmd_rom.sv
module fpc_cmd_rom
  import fpc_pkg::*;
#(
  parameter int unsigned BANK_AW = 13,
  parameter int unsigned IDX_W   = 13
) (
  input  fpc_op_t             op,
  input  logic [STEP_W-1:0]   step,
  input  logic                tail,
  input  logic [IDX_W-1:0]    idx,
  input  logic [7:0]          byte_in,
  output logic [BANK_AW-1:0]  ofs,
  output logic [7:0]          wdata,
  output logic                last
);
  localparam logic [BANK_AW-1:0] OFS_HI = BANK_AW'(KEY_OFS_HI);
  localparam logic [BANK_AW-1:0] OFS_LO = BANK_AW'(KEY_OFS_LO);

  always_comb begin
    ofs   = '0;
    wdata = BACK_TO_RD;
    last  = 1'b1;
    if (!tail) begin
      last = 1'b0;
      unique case (step)
        3'd0: begin ofs = OFS_HI; wdata = KEY_FIRST;  end
        3'd1: begin ofs = OFS_LO; wdata = KEY_SECOND; end
        3'd2: begin
          ofs   = OFS_HI;
          wdata = (op == OP_PROG) ? PROG_ARM : ERASE_ARM;
        end
        3'd3: begin
          if (op == OP_PROG) begin
            ofs   = BANK_AW'(idx);
            wdata = byte_in;
            last  = 1'b1;
          end else begin
            ofs   = OFS_HI;
            wdata = KEY_FIRST;
          end
        end
        3'd4: begin ofs = OFS_LO; wdata = KEY_SECOND; end
        default: begin ofs = '0; wdata = ERASE_GO; last = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/fpc_flash_ctrl.sv
module fpc_flash_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned BANK_AW  = 13,
  parameter int unsigned PROG_LEN = 8192,
  parameter int unsigned GAP_CYC  = 200,
  parameter int unsigned POLL_MAX = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_prog,
  input  logic               bank_sel,
  input  logic               src_valid,
  output logic               src_ready,
  input  logic [7:0]         src_data,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [BANK_AW:0]   fl_addr,
  output logic [7:0]         fl_wdata,
  input  logic [7:0]         fl_rdata,
  output logic               fl_we,
  output logic               fl_re
);
  localparam int unsigned IDX_W = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
  localparam int unsigned SW    = (GAP_CYC < 2) ? 2 : $clog2(GAP_CYC + 1) + 1;

  fpc_state_t          state;
  fpc_op_t             op_q;
  logic                bank_q;
  logic [STEP_W-1:0]   step_q;
  logic [IDX_W-1:0]    idx_q;
  logic [7:0]          byte_q;
  logic                tail_q;
  logic                fail_q;
  logic                done_q;
  logic                err_q;

  logic [BANK_AW-1:0]  rom_ofs;
  logic [7:0]          rom_wdata;
  logic                rom_last;
  logic                gap_expire;
  logic                poll_same;
  logic                poll_limit;
  logic                poll_clear;
  logic                last_byte;
  logic                polling;

  fpc_cmd_rom #(.BANK_AW(BANK_AW), .IDX_W(IDX_W)) u_rom (
    .op      (op_q),
    .step    (step_q),
    .tail    (tail_q),
    .idx     (idx_q),
    .byte_in (byte_q),
    .ofs     (rom_ofs),
    .wdata   (rom_wdata),
    .last    (rom_last)
  );

  fpc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (state == S_WRITE),
    .expire (gap_expire)
  );

  assign poll_clear = (state == S_GAP) && gap_expire && rom_last && !tail_q;

  fpc_toggle_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (poll_clear),
    .cap   (state == S_RD_A),
    .cmp   (state == S_RD_B),
    .rdata (fl_rdata),
    .same  (poll_same),
    .limit (poll_limit)
  );

  assign last_byte = (idx_q == IDX_W'(PROG_LEN - 1));
  assign polling   = (state == S_RD_A) || (state == S_RD_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_ERASE;
      bank_q <= 1'b0;
      step_q <= '0;
      idx_q  <= '0;
      byte_q <= '0;
      tail_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            op_q   <= fpc_op_t'(op_prog);
            bank_q <= bank_sel;
            step_q <= '0;
            idx_q  <= '0;
            tail_q <= 1'b0;
            fail_q <= 1'b0;
            err_q  <= 1'b0;
            state  <= S_WRITE;
          end
        end
        S_FETCH: begin
          if (src_valid) begin
            byte_q <= src_data;
            state  <= S_WRITE;
          end
        end
        S_WRITE: state <= S_GAP;
        S_GAP: begin
          if (gap_expire) begin
            if (tail_q)
              state <= S_FIN;
            else if (rom_last)
              state <= S_RD_A;
            else begin
              step_q <= step_q + 1'b1;
              state  <= (op_q == OP_PROG && step_q == 3'd2) ? S_FETCH : S_WRITE;
            end
          end
        end
        S_RD_A: state <= S_RD_B;
        S_RD_B: begin
          if (poll_same) begin
            if (op_q == OP_ERASE || last_byte) begin
              tail_q <= 1'b1;
            end else begin
              idx_q  <= idx_q + 1'b1;
              step_q <= '0;
            end
            state <= S_WRITE;
          end else if (poll_limit) begin
            fail_q <= 1'b1;
            tail_q <= 1'b1;
            state  <= S_WRITE;
          end else begin
            state <= S_RD_A;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          err_q  <= fail_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fl_addr   = {bank_q, polling ? {BANK_AW{1'b0}} : rom_ofs};
  assign fl_wdata  = rom_wdata;
  assign fl_we     = (state == S_WRITE);
  assign fl_re     = polling;
  assign src_ready = (state == S_FETCH);
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;

  // Cycles since the last write strobe, saturating (assertion support)
  logic [SW-1:0] since_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_we <= SW'(GAP_CYC);
    else if (fl_we)
      since_we <= '0;
    else if (since_we < SW'(GAP_CYC))
      since_we <= since_we + 1'b1;
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);  // R1
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));  // R11
  AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> since_we >= SW'(GAP_CYC));  // R5
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_re) |=> fl_re);  // R6
  AST_POLL_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> fl_addr[BANK_AW-1:0] == '0);  // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);  // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !fl_we && !fl_re);  // R4

endmodule

// File: tb/sim_fpc_flash_ctrl.sv
`timescale 1ns/1ps
module sim_fpc_flash_ctrl;
  localparam int BANK_AW  = 13;
  localparam int PROG_LEN = 12;
  localparam int GAP_CYC  = 3;
  localparam int POLL_MAX = 6;
  localparam int AW       = BANK_AW + 1;
  localparam int BANK_SZ  = 1 << BANK_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_prog = 1'b0, bank_sel = 1'b0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [7:0] src_data;
  logic busy, done, error;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re;

  always #2.5 clk = ~clk;

  fpc_flash_ctrl #(.BANK_AW(BANK_AW), .PROG_LEN(PROG_LEN), .GAP_CYC(GAP_CYC),
                   .POLL_MAX(POLL_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank_sel(bank_sel),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .busy(busy), .done(done), .error(error), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re));

  // ---------------- flash model and bus monitor ----------------
  logic [7:0]  mem [0:(1<<AW)-1];
  logic [21:0] wlog [$];
  logic        tog = 1'b0;
  logic        armed = 1'b0;
  int          busy_left = 0;
  int          prog_seen = 0;
  int          rd_cnt = 0;
  int          gap_run = 1000;
  int          min_gap = 1000;
  int          bad_rd = 0;
  int          overlap = 0;
  int          src_ptr = 0;
  int          norm_busy = 0, fail_busy = 0, fail_at = -1;
  bit          stall_en = 1'b0;
  logic [7:0]  buf_data [0:PROG_LEN-1];

  assign fl_rdata = mem[fl_addr] ^ (tog ? 8'h40 : 8'h00);
  assign src_data = buf_data[(src_ptr < PROG_LEN) ? src_ptr : 0];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (start && !busy) begin prog_seen <= 0; src_ptr <= 0; end
      if (src_valid && src_ready) src_ptr <= src_ptr + 1;
      if (fl_we && fl_re) overlap <= overlap + 1;
      if (fl_re) begin
        rd_cnt <= rd_cnt + 1;
        if (fl_addr[BANK_AW-1:0] != 0) bad_rd <= bad_rd + 1;
        if (busy_left > 0) begin tog <= ~tog; busy_left <= busy_left - 1; end
      end
      if (fl_we) begin
        wlog.push_back({fl_addr, fl_wdata});
        if (gap_run < min_gap) min_gap <= gap_run;
        gap_run <= 0;
        if (armed) begin
          mem[fl_addr] <= mem[fl_addr] & fl_wdata;
          armed <= 1'b0;
          busy_left <= (prog_seen == fail_at) ? fail_busy : norm_busy;
          prog_seen <= prog_seen + 1;
        end else if (fl_wdata == 8'hA0 && fl_addr[BANK_AW-1:0] == 13'h555) begin
          armed <= 1'b1;
        end else if (fl_wdata == 8'h30 && fl_addr[BANK_AW-1:0] == 0) begin
          for (int i = 0; i < BANK_SZ; i++) mem[{fl_addr[BANK_AW], 13'(i)}] <= 8'hFF;
          busy_left <= norm_busy;
        end
      end else begin
        gap_run <= gap_run + 1;
      end
    end
  end

  always @(negedge clk)
    src_valid <= stall_en ? ($urandom % 3 != 0) : 1'b1;

  // ---------------- checking ----------------
  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit times_out(input int b);
    return ((b + 1) / 2) >= POLL_MAX;
  endfunction

  function automatic int reads_for(input int b);
    if (times_out(b)) return 2 * POLL_MAX;
    return 2 * ((b + 1) / 2 + 1);
  endfunction

  function automatic logic [21:0] ent(input bit bk, input int ofs, input logic [7:0] d);
    return {bk, 13'(ofs), d};
  endfunction

  task automatic run_op(input bit prog, input bit bank, input int nb, input int fa,
                        input int fb, input bit stall, input bit extra);
    logic [21:0] exp_q [$];
    logic [7:0]  pre [0:PROG_LEN-1];
    int  exp_rd = 0;
    bit  exp_err = 1'b0;
    int  lstart, rstart, n, bad;
    string rq;
    norm_busy = nb; fail_at = fa; fail_busy = fb; stall_en = stall;
    for (int i = 0; i < PROG_LEN; i++) begin
      buf_data[i] = 8'($urandom);
      pre[i] = mem[{bank, 13'(i)}];
    end
    // expected bus script
    if (prog) begin
      for (int i = 0; i < PROG_LEN; i++) begin
        int b = (i == fa) ? fb : nb;
        exp_q.push_back(ent(bank, 'h555, 8'hAA));
        exp_q.push_back(ent(bank, 'h2AA, 8'h55));
        exp_q.push_back(ent(bank, 'h555, 8'hA0));
        exp_q.push_back(ent(bank, i, buf_data[i]));
        exp_rd += reads_for(b);
        if (times_out(b)) begin exp_err = 1'b1; break; end
      end
    end else begin
      exp_q.push_back(ent(bank, 'h555, 8'hAA));
      exp_q.push_back(ent(bank, 'h2AA, 8'h55));
      exp_q.push_back(ent(bank, 'h555, 8'h80));
      exp_q.push_back(ent(bank, 'h555, 8'hAA));
      exp_q.push_back(ent(bank, 'h2AA, 8'h55));
      exp_q.push_back(ent(bank, 0, 8'h30));
      exp_rd = reads_for(nb);
      exp_err = times_out(nb);
    end
    exp_q.push_back(ent(bank, 0, 8'hF0));
    rq = prog ? (exp_err ? "R7" : "R4") : "R3";

    lstart = wlog.size(); rstart = rd_cnt;
    @(negedge clk); start = 1'b1; op_prog = prog; bank_sel = bank;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    chk(error == 1'b0, "R10", "error cleared by start", error, 0);
    if (extra) begin
      repeat (5) @(negedge clk);
      start = 1'b1; op_prog = ~prog; bank_sel = ~bank;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R8", "done seen before watchdog", done, 1);
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    chk(error == exp_err, rq, "error at done", error, exp_err);
    chk(wlog.size() - lstart == exp_q.size(), extra ? "R1" : rq, "write count",
        wlog.size() - lstart, exp_q.size());
    bad = -1;
    for (int i = 0; i < exp_q.size() && lstart + i < wlog.size(); i++)
      if (wlog[lstart + i] != exp_q[i] && bad < 0) bad = i;
    chk(bad < 0, "R2", "write script match", (bad < 0) ? 0 : wlog[lstart + bad],
        (bad < 0) ? 0 : exp_q[bad]);
    bad = 0;
    for (int i = lstart; i < wlog.size(); i++) if (wlog[i][21] != bank) bad++;
    chk(bad == 0, "R9", "bank bit on writes", bad, 0);
    chk(rd_cnt - rstart == exp_rd, "R6", "poll read count", rd_cnt - rstart, exp_rd);
    if (prog) begin
      int want = exp_err ? fa + 1 : PROG_LEN;
      chk(src_ptr == want, "R4", "bytes taken from stream", src_ptr, want);
      if (!exp_err) begin
        bad = -1;
        for (int i = 0; i < PROG_LEN; i++)
          if (mem[{bank, 13'(i)}] != (pre[i] & buf_data[i]) && bad < 0) bad = i;
        chk(bad < 0, "R4", "programmed bytes", bad, -1);
      end
    end else begin
      bad = 0;
      for (int i = 0; i < BANK_SZ; i++) if (mem[{bank, 13'(i)}] != 8'hFF) bad++;
      chk(bad == 0, "R3", "bytes not erased", bad, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R11", "reset outputs",
        {busy, done, error}, 0);
    chk(fl_we == 1'b0 && fl_re == 1'b0, "R11", "reset strobes", {fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(1'b0, 1'b0, 3, -1, 0, 1'b0, 1'b0);                 // R3 bank 0
    run_op(1'b0, 1'b1, 0, -1, 0, 1'b0, 1'b1);                 // R1 ignored start
    run_op(1'b1, 1'b1, 2, -1, 0, 1'b1, 1'b0);                 // R4 with stalls
    run_op(1'b1, 1'b0, 2 * POLL_MAX - 2, -1, 0, 1'b0, 1'b0);  // R6 longest success
    run_op(1'b1, 1'b0, 1, 4, 2 * POLL_MAX - 1, 1'b1, 1'b0);   // R7 first timeout
    run_op(1'b0, 1'b0, 2 * POLL_MAX, -1, 0, 1'b0, 1'b0);      // R7 erase timeout
    run_op(1'b0, 1'b1, 1, -1, 0, 1'b0, 1'b0);                 // R10 error cleared
    for (int k = 0; k < 6; k++) begin
      bit bk = 1'($urandom);
      run_op(1'b0, bk, int'($urandom % 5), -1, 0, 1'b0, 1'b0);
      run_op(1'b1, bk, int'($urandom % 5), -1, 0, 1'($urandom), 1'b0);
    end

    chk(min_gap >= GAP_CYC, "R5", "minimum quiet cycles between writes", min_gap, GAP_CYC);
    chk(bad_rd == 0, "R6", "reads away from bank base", bad_rd, 0);
    chk(overlap == 0, "R11", "write and read together", overlap, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule